// File: doc/BRIEF.md
# Regulator Start-Up Sequencer

This block brings a multiphase buck regulator controller from power-off to regulated output in a fixed order. It waits for both the supply-OK and the enable inputs to be high. After a fixed settling delay it turns on the soft-start ramp, with the reference aimed first at a fixed boot voltage. Once that ramp has landed, it switches the reference to the level chosen by the voltage code and waits for the second ramp to land. The power-good output goes high only after a long settling interval, counted from the start of the first ramp, has run out.

For the whole start-up the block raises a flag that forces the controller to run both phases in continuous conduction, whatever its mode-select inputs ask for. All delays are counted in pulses of a microsecond tick, and the delay lengths are parameters so that a bench can use short values. The analog soft-start current, the DAC and the comparators sit outside this block. It deals only with state and timing.

If the supply or the enable drops, the sequence returns at once to the idle state. When both come back, the full sequence runs again from the start. This is the only way out of a latched fault.

Top module: `vreg_startup_seq`

## Requirements
- R1: The sequencer leaves the idle state only at a clock edge where `supply_ok` and `enable` are both high. `seq_state` encodes the states as follows: 0 idle, 1 pre-ramp wait, 2 boot ramp, 3 target ramp, 4 settle, 5 run.
- R2: At any clock edge where `supply_ok` or `enable` is low, the next state is idle (0), from any state. In idle, `soft_start_en`, `ref_sel_code`, `startup_active` and `pgood` are all low.
- R3: The wait state (1) lasts until exactly WAIT_TICKS `us_tick` pulses have been counted in it. The boot ramp (2) follows, and `soft_start_en` is high in states 2 through 5.
- R4: In the boot ramp, `ref_sel_code` is 0, which selects the fixed boot level. A high `ramp_done` moves the sequence to the target ramp (3). `ref_sel_code` is 1, selecting the coded level, in states 3, 4 and 5.
- R5: The target ramp ignores `ramp_done` in its first cycle. It moves to settle (4) on a high `ramp_done` in any later cycle, so it lasts at least two cycles.
- R6: Settle moves to run (5) once SETTLE_TICKS tick pulses have been counted since the boot ramp began. If that count has already run out, settle lasts exactly one cycle.
- R7: `startup_active`, the force-two-phase flag, is high in states 1 to 4 and low in idle and run.
- R8: `pgood` is high only in run while `fault_latched` is low. A set fault latch pulls `pgood` low in the same cycle and does not change the state.
- R9: Leaving idle again after any drop restarts the full sequence, with both delay counts starting from zero.
- R10: Under reset the state is idle and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| supply_ok | input | 1 | Supply is above its power-on-reset level |
| enable | input | 1 | Regulator enable request |
| ramp_done | input | 1 | Reference generator has reached its current target |
| fault_latched | input | 1 | Protection fault latch is set |
| soft_start_en | output | 1 | Enables the soft-start ramp |
| ref_sel_code | output | 1 | 0 selects the boot level, 1 selects the coded level |
| startup_active | output | 1 | Start-up in progress; forces two-phase operation |
| pgood | output | 1 | Power good |
| seq_state | output | 3 | Current sequence state (encoding in R1) |

## Verification
The sequence is driven in four ways:
- **Slow ramp-done handshake.** This shows that the wait and settle lengths come from tick counts and not from the ramps.
- **`ramp_done` held high throughout.** This separates the one-cycle blanking of the target ramp from a plain pass-through.
- **Target ramp that lands after the settle count has run out.** This shows that power-good waits for the ramp, and that settle then lasts one cycle.
- **Supply drop in mid-ramp and an enable drop during a fault.** These show the immediate return to idle and a full restart with fresh counts.

Power-good is also checked while only one of the two qualifying inputs is high, and while the fault latch is set in run.

// File: rtl/vreg_startup_pkg.sv
package vreg_startup_pkg;

  typedef enum logic [2:0] {
    ST_OFF         = 3'd0,
    ST_WAIT        = 3'd1,
    ST_RAMP_BOOT   = 3'd2,
    ST_RAMP_TARGET = 3'd3,
    ST_SETTLE      = 3'd4,
    ST_RUN         = 3'd5
  } seq_state_e;

  // soft-start ramp is on from the first ramp onwards
  function automatic logic ss_on(input seq_state_e st);
    return (st == ST_RAMP_BOOT) || (st == ST_RAMP_TARGET) ||
           (st == ST_SETTLE) || (st == ST_RUN);
  endfunction

  // reference follows the voltage code once the boot ramp has landed
  function automatic logic code_selected(input seq_state_e st);
    return (st == ST_RAMP_TARGET) || (st == ST_SETTLE) || (st == ST_RUN);
  endfunction

  // start-up window in which two-phase operation is forced
  function automatic logic in_startup(input seq_state_e st);
    return (st == ST_WAIT) || (st == ST_RAMP_BOOT) ||
           (st == ST_RAMP_TARGET) || (st == ST_SETTLE);
  endfunction

endpackage

// File: rtl/vreg_tick_timer.sv
module vreg_tick_timer #(
  parameter int unsigned LIMIT = 100,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic done
);

  localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  // saturating tick counter, held at zero while clr is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr)              cnt_q <= '0;
    else if (tick && !done)    cnt_q <= cnt_q + CW'(1);
  end

  assign done = (cnt_q == LIMIT_C);

endmodule

// File: rtl/vreg_seq_fsm.sv
module vreg_seq_fsm
  import vreg_startup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       qualified,
  input  logic       wait_done,
  input  logic       settle_done,
  input  logic       ramp_done,
  output seq_state_e state_q,
  output logic       target_entry
);

  seq_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (!qualified) begin
      state_d = ST_OFF;
    end else begin
      case (state_q)
        ST_OFF:         state_d = ST_WAIT;
        ST_WAIT:        if (wait_done)                  state_d = ST_RAMP_BOOT;
        ST_RAMP_BOOT:   if (ramp_done)                  state_d = ST_RAMP_TARGET;
        ST_RAMP_TARGET: if (ramp_done && !target_entry) state_d = ST_SETTLE;
        ST_SETTLE:      if (settle_done)                state_d = ST_RUN;
        ST_RUN:         state_d = ST_RUN;
        default:        state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_OFF;
      target_entry <= 1'b0;
    end else begin
      state_q      <= state_d;
      // high during the first cycle spent in the target ramp
      target_entry <= (state_d == ST_RAMP_TARGET) && (state_q != ST_RAMP_TARGET);
    end
  end

endmodule

// File: rtl/vreg_startup_seq.sv
module vreg_startup_seq
  import vreg_startup_pkg::*;
#(
  parameter int unsigned WAIT_TICKS   = 100,
  parameter int unsigned SETTLE_TICKS = 7000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       supply_ok,
  input  logic       enable,
  input  logic       ramp_done,
  input  logic       fault_latched,
  output logic       soft_start_en,
  output logic       ref_sel_code,
  output logic       startup_active,
  output logic       pgood,
  output logic [2:0] seq_state
);

  seq_state_e state;
  logic       qualified;
  logic       wait_done;
  logic       settle_done;
  logic       target_entry;
  logic       wait_clr;
  logic       settle_clr;

  assign qualified  = supply_ok && enable;
  assign wait_clr   = (state != ST_WAIT);
  assign settle_clr = (state == ST_OFF) || (state == ST_WAIT);

  vreg_tick_timer #(.LIMIT(WAIT_TICKS)) u_wait_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (wait_clr),
    .tick (us_tick),
    .done (wait_done)
  );

  vreg_tick_timer #(.LIMIT(SETTLE_TICKS)) u_settle_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (settle_clr),
    .tick (us_tick),
    .done (settle_done)
  );

  vreg_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .qualified   (qualified),
    .wait_done   (wait_done),
    .settle_done (settle_done),
    .ramp_done   (ramp_done),
    .state_q     (state),
    .target_entry(target_entry)
  );

  assign soft_start_en  = ss_on(state);
  assign ref_sel_code   = code_selected(state);
  assign startup_active = in_startup(state);
  assign pgood          = (state == ST_RUN) && !fault_latched;
  assign seq_state      = state;

endmodule

// File: rtl/vreg_startup_seq_chk.sv
module vreg_startup_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic       enable,
  input logic       ramp_done,
  input logic       fault_latched,
  input logic       ref_sel_code,
  input logic       startup_active,
  input logic       pgood,
  input logic [2:0] seq_state,
  input logic       wait_done,
  input logic       settle_done,
  input logic       target_entry
);

  a_r1_leave_idle_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd1 && $past(seq_state) == 3'd0) |-> $past(supply_ok && enable));

  a_r2_drop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(supply_ok && enable) |=> (seq_state == 3'd0));

  a_r3_boot_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd2 && $past(seq_state) != 3'd2) |->
      ($past(seq_state) == 3'd1 && $past(wait_done)));

  a_r4_code_after_boot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_sel_code) |-> ($past(seq_state) == 3'd2 && $past(ramp_done)));

  a_r5_target_blanked: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd4 && $past(seq_state) == 3'd3) |->
      ($past(ramp_done) && !$past(target_entry)));

  a_r6_run_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd5 && $past(seq_state) != 3'd5) |->
      ($past(seq_state) == 3'd4 && $past(settle_done)));

  a_r7_no_force_with_pgood: assert property (@(posedge clk) disable iff (!rst_n)
    startup_active |-> !pgood);

  a_r8_pgood_gated: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> (seq_state == 3'd5 && !fault_latched));

endmodule

bind vreg_startup_seq vreg_startup_seq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .supply_ok     (supply_ok),
  .enable        (enable),
  .ramp_done     (ramp_done),
  .fault_latched (fault_latched),
  .ref_sel_code  (ref_sel_code),
  .startup_active(startup_active),
  .pgood         (pgood),
  .seq_state     (seq_state),
  .wait_done     (wait_done),
  .settle_done   (settle_done),
  .target_entry  (target_entry)
);

// File: tb/vreg_startup_seq_bench.sv
module vreg_startup_seq_bench;

  localparam int WT = 5;
  localparam int ST = 40;

  logic clk = 1'b0;
  logic rst_n;
  logic us_tick;
  logic supply_ok, enable, ramp_done, fault_latched;
  logic soft_start_en, ref_sel_code, startup_active, pgood;
  logic [2:0] seq_state;

  always #10 clk = ~clk;

  vreg_startup_seq #(.WAIT_TICKS(WT), .SETTLE_TICKS(ST)) u_vreg_startup_seq (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .supply_ok(supply_ok),
    .enable(enable), .ramp_done(ramp_done), .fault_latched(fault_latched),
    .soft_start_en(soft_start_en), .ref_sel_code(ref_sel_code),
    .startup_active(startup_active), .pgood(pgood), .seq_state(seq_state)
  );

  int checks = 0;
  int fails  = 0;
  bit mon_on = 1'b0;

  // kind: 0 none, 1 ticks in previous state, 2 ticks since boot ramp, 3 cycles in previous state
  typedef struct {
    int    st;
    int    kind;
    int    val;
    string req;
  } exp_t;
  exp_t exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int st, input int kind, input int val, input string req);
    exp_t e;
    e.st = st; e.kind = kind; e.val = val; e.req = req;
    exp_q.push_back(e);
  endtask

  // tick: one cycle high in every four, changed shortly after the edge
  initial begin
    us_tick = 1'b0;
    for (int i = 0; ; i++) begin
      @(posedge clk); #3;
      us_tick = ((i % 4) == 3);
    end
  end

  // monitor: pops an expected item at every state change
  int prev_st = 0, cyc = 0, ticks_in = 0, ramp_ticks = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (int'(seq_state) != prev_st) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected transition", int'(seq_state), prev_st);
        end else begin
          exp_t e;
          int   want;
          e = exp_q.pop_front();
          chk(int'(seq_state) == e.st, {e.req, " state"}, int'(seq_state), e.st);
          if (e.kind == 1) chk(ticks_in == e.val, "R3 wait ticks", ticks_in, e.val);
          if (e.kind == 2) chk(ramp_ticks == e.val, "R6 settle ticks", ramp_ticks, e.val);
          if (e.kind == 3) chk(cyc == e.val, {e.req, " cycles"}, cyc, e.val);
          want = ((seq_state >= 3'd1 && seq_state <= 3'd4) ? 1 : 0);
          chk(int'(startup_active) == want, "R7 startup_active", int'(startup_active), want);
          want = ((seq_state >= 3'd2) ? 1 : 0) + ((seq_state >= 3'd3) ? 2 : 0);
          chk(int'({ref_sel_code, soft_start_en}) == want, "R4 soft/ref select",
              int'({ref_sel_code, soft_start_en}), want);
          want = (seq_state == 3'd5 && !fault_latched) ? 1 : 0;
          chk(int'(pgood) == want, "R8 pgood", int'(pgood), want);
        end
        prev_st = int'(seq_state);
        cyc = 0;
        ticks_in = 0;
        if (seq_state <= 3'd1) ramp_ticks = 0;
      end
      cyc++;
      if (us_tick) begin
        ticks_in++;
        if (seq_state >= 3'd2 && seq_state <= 3'd4) ramp_ticks++;
      end
    end
  end

  task automatic drive(input logic s, input logic e, input logic r, input logic f);
    @(posedge clk); #3;
    supply_ok = s; enable = e; ramp_done = r; fault_latched = f;
  endtask

  task automatic wait_state(input int st, input string req);
    int n = 0;
    while (int'(seq_state) != st && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (int'(seq_state) != st) chk(1'b0, {req, " timeout"}, int'(seq_state), st);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd >= 200000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    supply_ok = 1'b0; enable = 1'b0; ramp_done = 1'b0; fault_latched = 1'b0;
    idle(4);
    @(negedge clk);
    chk(seq_state == 3'd0 && !soft_start_en && !ref_sel_code && !startup_active && !pgood,
        "R10 reset outputs", int'({seq_state, soft_start_en, ref_sel_code, startup_active, pgood}), 0);
    @(posedge clk); #3;
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R1: one qualifier alone keeps the block idle
    drive(1'b0, 1'b1, 1'b0, 1'b0);
    idle(30); @(negedge clk);
    chk(seq_state == 3'd0 && !pgood, "R1 enable without supply", int'(seq_state), 0);
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    idle(30); @(negedge clk);
    chk(seq_state == 3'd0 && !soft_start_en, "R1 supply without enable", int'(seq_state), 0);

    // main sequence with a slow ramp handshake
    push(1, 0, 0, "R1"); push(2, 1, WT, "R3"); push(3, 0, 0, "R4");
    push(4, 0, 0, "R5"); push(5, 2, ST, "R6");
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    wait_state(2, "R3");
    idle(10);
    drive(1'b1, 1'b1, 1'b1, 1'b0);
    wait_state(3, "R4");
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    idle(10);
    drive(1'b1, 1'b1, 1'b1, 1'b0);
    wait_state(5, "R6");
    @(negedge clk);
    chk(pgood == 1'b1, "R8 pgood in run", int'(pgood), 1);

    // fault in run: pgood drops at once, state held
    drive(1'b1, 1'b1, 1'b1, 1'b1);
    #2;
    chk(pgood == 1'b0, "R8 fault forces pgood low", int'(pgood), 0);
    idle(5); @(negedge clk);
    chk(seq_state == 3'd5 && !pgood, "R8 fault keeps state", int'(seq_state), 5);

    // enable drop clears, then full restart with ramp_done held high
    push(0, 0, 0, "R2");
    drive(1'b1, 1'b0, 1'b1, 1'b1);
    wait_state(0, "R2");
    push(1, 0, 0, "R9"); push(2, 1, WT, "R9"); push(3, 3, 1, "R4");
    push(4, 3, 2, "R5"); push(5, 2, ST, "R9");
    drive(1'b1, 1'b1, 1'b1, 1'b0);
    wait_state(5, "R9");
    idle(3);

    // supply drop in mid boot ramp
    push(0, 0, 0, "R2");
    drive(1'b0, 1'b1, 1'b0, 1'b0);
    wait_state(0, "R2");
    push(1, 0, 0, "R9"); push(2, 1, WT, "R9"); push(0, 0, 0, "R2");
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    wait_state(2, "R9");
    idle(3);
    drive(1'b0, 1'b1, 1'b0, 1'b0);
    wait_state(0, "R2");
    idle(3);

    // target ramp lands after the settle count has expired
    push(1, 0, 0, "R1"); push(2, 1, WT, "R3"); push(3, 0, 0, "R4");
    push(4, 0, 0, "R5"); push(5, 3, 1, "R6");
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    wait_state(2, "R3");
    drive(1'b1, 1'b1, 1'b1, 1'b0);
    wait_state(3, "R4");
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    idle(200); @(negedge clk);
    chk(seq_state == 3'd3 && !pgood, "R6 pgood waits for ramp", int'(seq_state), 3);
    drive(1'b1, 1'b1, 1'b1, 1'b0);
    wait_state(5, "R6");
    idle(5);
    chk(exp_q.size() == 0, "R9 pending transitions", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule